// File: doc/BRIEF.md
# Miss Latency Histogram Monitor

This block sits beside a blocking cache and gathers performance statistics for it. It keeps saturating counts of hits, misses and completed fills. It also measures, in clock cycles, how long each miss takes from the cycle it is flagged until the fill returns. Every latency lands in one of a fixed number of equal-width bins, so software can read back the shape of the miss latency distribution. The hit ratio is left to software, which forms hits / (hits + misses) from the two counters.

The bin width starts at one cycle and is always a power of two. When a latency is too large for the current range, the block does not drop it or clip it. It doubles the bin width, merging neighbouring bins in pairs, one merge step per clock, until the held sample fits. No earlier sample is lost. A fill that completes while merges are still running is placed at the scale in force after that cycle's merge. A synchronous clear brings every count back to zero and the width back to one cycle.

Top module: `mlh_miss_histogram`

## Requirements
- R1: `hit_count_o` increases by one on each clock edge that samples `hit_i` high. It holds at all-ones instead of wrapping.
- R2: `miss_count_o` increases by one on each clock edge that samples `miss_i` high. It holds at all-ones instead of wrapping.
- R3: `sample_count_o` increases by one on each clock edge that samples `fill_i` high. It holds at all-ones instead of wrapping.
- R4: Latency L is the number of clock edges from the edge that samples `miss_i` to the edge that samples `fill_i`. When no sample is held and (L >> s) < NUM_BINS, bin L >> s is incremented at the fill edge. Here s is `bin_shift_o`, the bin width is 2^s cycles, and bin k is `bins_o[k*BIN_W +: BIN_W]`.
- R5: After reset or clear, s is 0. Apart from clear, s only ever grows, and by at most one per clock. Its largest value is LAT_W - log2(NUM_BINS).
- R6: One merge step raises s by one. After the step, bin k for k < NUM_BINS/2 holds the saturating sum of the former bins 2k and 2k+1, and the upper half holds zero, apart from any sample binned in that same cycle.
- R7: A sample with (L >> s) >= NUM_BINS is held. A merge step runs on each following clock, and the sample is added to bin L >> s in the cycle of the step after which it first fits.
- R8: A fill sampled while a held sample is still waiting is added in that same cycle to bin L >> (s+1), counted at the scale after that cycle's merge. No sample is dropped.
- R9: A bin holds at 2^BIN_W - 1, both when it is incremented and when two bins are merged into it.
- R10: `clear_i` zeroes all counters and bins, sets s to 0 and drops any held sample. It takes priority over every strobe in the same cycle.
- R11: The largest latency, 2^LAT_W - 1, fits once s reaches its maximum value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all statistics |
| hit_i | input | 1 | Cache hit strobe |
| miss_i | input | 1 | Cache miss strobe; captures the start time |
| fill_i | input | 1 | Fill-complete strobe; ends the latency sample |
| hit_count_o | output | CNT_W | Saturating hit count |
| miss_count_o | output | CNT_W | Saturating miss count |
| sample_count_o | output | CNT_W | Saturating latency sample count |
| bin_shift_o | output | $clog2(LAT_W-$clog2(NUM_BINS)+1) | log2 of the current bin width in cycles |
| bins_o | output | NUM_BINS*BIN_W | Bin counts; bin k at bits k*BIN_W +: BIN_W |

## Verification
A fault in the held-sample state or the shift register shows up at the ports within a few clocks. `bin_shift_o` either stalls below the width the largest sample needs or steps past it. The sample then turns up in the wrong bin, or in no bin at all, once the merge sequence settles. A fault in the merge adder shows as bin sums that no longer add up to the sample count, right after the first width change. The bench compares every bin against an independent model after each sample, so either fault is caught at the first sample that follows it.

// File: rtl/mlh_pkg.sv
package mlh_pkg;
  // What the histogram does on a given cycle
  typedef enum logic [1:0] {
    CTL_IDLE   = 2'd0,  // nothing to bin
    CTL_DIRECT = 2'd1,  // new sample fits the current scale
    CTL_PARK   = 2'd2,  // new sample too large, hold it
    CTL_MERGE  = 2'd3   // held sample present: widen bins by one step
  } ctl_mode_e;
endpackage

// File: rtl/mlh_sat_counter.sv
module mlh_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mlh_latency_timer.sv
module mlh_latency_timer #(
  parameter int LAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  output logic [LAT_W-1:0] lat_o
);
  logic [LAT_W-1:0] ts_q, ts_d;
  logic [LAT_W-1:0] stamp_q;
  logic             ts_en;

  always_comb begin
    ts_en = 1'b1;
    ts_d  = ts_q + 1'b1;
  end

  // free-running time base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ts_q <= '0;
    else if (ts_en) ts_q <= ts_d;
  end

  // time of the most recent miss
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stamp_q <= '0;
    else if (miss_i) stamp_q <= ts_q;
  end

  // modular difference: edges elapsed since the miss edge
  assign lat_o = ts_q - stamp_q;
endmodule

// File: rtl/mlh_bin_array.sv
module mlh_bin_array #(
  parameter int NUM_BINS = 16,
  parameter int BIN_W    = 16,
  parameter int IDX_W    = $clog2(NUM_BINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      merge_i,
  input  logic                      a_en_i,
  input  logic [IDX_W-1:0]          a_idx_i,
  input  logic                      b_en_i,
  input  logic [IDX_W-1:0]          b_idx_i,
  output logic [NUM_BINS*BIN_W-1:0] bins_o
);
  localparam int             HALF    = NUM_BINS / 2;
  localparam logic [BIN_W-1:0] BIN_MAX = '1;

  logic [NUM_BINS*BIN_W-1:0] bins_flat;

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    logic [BIN_W-1:0] bin_q, bin_d, merged, base;
    logic [BIN_W:0]   pair_sum;
    logic [BIN_W+1:0] sum;
    logic [1:0]       add;
    logic             a_hit, b_hit, bin_en;

    if (k < HALF) begin : g_lower
      assign pair_sum = {1'b0, bins_flat[(2*k)*BIN_W +: BIN_W]}
                      + {1'b0, bins_flat[(2*k+1)*BIN_W +: BIN_W]};
      assign merged   = pair_sum[BIN_W] ? BIN_MAX : pair_sum[BIN_W-1:0];
    end else begin : g_upper
      assign pair_sum = '0;
      assign merged   = '0;
    end

    always_comb begin
      a_hit  = a_en_i && (a_idx_i == IDX_W'(k));
      b_hit  = b_en_i && (b_idx_i == IDX_W'(k));
      add    = {1'b0, a_hit} + {1'b0, b_hit};
      base   = merge_i ? merged : bin_q;
      sum    = {2'b00, base} + {{BIN_W{1'b0}}, add};
      bin_en = clr_i | merge_i | a_hit | b_hit;
      if (clr_i)                      bin_d = '0;
      else if (sum[BIN_W+1:BIN_W] != 2'b00) bin_d = BIN_MAX;
      else                            bin_d = sum[BIN_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bin_q <= '0;
      else if (bin_en) bin_q <= bin_d;
    end

    assign bins_flat[k*BIN_W +: BIN_W] = bin_q;
  end

  assign bins_o = bins_flat;
endmodule

// File: rtl/mlh_miss_histogram.sv
module mlh_miss_histogram
  import mlh_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int CNT_W    = 32,
  parameter int BIN_W    = 32,
  parameter int LAT_W    = 16,
  localparam int IDX_W     = $clog2(NUM_BINS),
  localparam int MAX_SHIFT = LAT_W - IDX_W,
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      hit_i,
  input  logic                      miss_i,
  input  logic                      fill_i,
  output logic [CNT_W-1:0]          hit_count_o,
  output logic [CNT_W-1:0]          miss_count_o,
  output logic [CNT_W-1:0]          sample_count_o,
  output logic [SHIFT_W-1:0]        bin_shift_o,
  output logic [NUM_BINS*BIN_W-1:0] bins_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BINS - 1);

  // ---------------- event counters ----------------
  mlh_sat_counter #(.W(CNT_W)) u_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .inc_i(hit_i),  .cnt_o(hit_count_o));
  mlh_sat_counter #(.W(CNT_W)) u_miss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .inc_i(miss_i), .cnt_o(miss_count_o));
  mlh_sat_counter #(.W(CNT_W)) u_smp_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .inc_i(fill_i), .cnt_o(sample_count_o));

  // ---------------- latency measurement ----------------
  logic [LAT_W-1:0] lat;

  mlh_latency_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .miss_i(miss_i), .lat_o(lat));

  // ---------------- scale and held sample ----------------
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic               shift_en;
  logic               pend_q, pend_d, pend_en;
  logic [LAT_W-1:0]   pend_lat_q, pend_lat_d;

  logic [SHIFT_W:0]   shift_up;
  logic [LAT_W-1:0]   scaled_now, scaled_up, pend_up;
  logic               fits_now, fits_up, pend_fits_up;
  ctl_mode_e          mode;

  logic               merge;
  logic               a_en, b_en;
  logic [IDX_W-1:0]   a_idx, b_idx;

  always_comb begin
    shift_up     = {1'b0, shift_q} + 1'b1;
    scaled_now   = lat >> shift_q;
    scaled_up    = lat >> shift_up;
    pend_up      = pend_lat_q >> shift_up;
    fits_now     = (scaled_now >> IDX_W) == '0;
    fits_up      = (scaled_up  >> IDX_W) == '0;
    pend_fits_up = (pend_up    >> IDX_W) == '0;

    if (clear_i)     mode = CTL_IDLE;
    else if (pend_q) mode = CTL_MERGE;
    else if (fill_i) mode = fits_now ? CTL_DIRECT : CTL_PARK;
    else             mode = CTL_IDLE;
  end

  // bin update controls
  always_comb begin
    merge = (mode == CTL_MERGE);
    a_en  = (mode == CTL_DIRECT) | (merge & pend_fits_up);
    a_idx = (mode == CTL_DIRECT) ? scaled_now[IDX_W-1:0] : pend_up[IDX_W-1:0];
    // a fill during a merge sequence is placed at the widened scale
    b_en  = merge & fill_i;
    b_idx = fits_up ? scaled_up[IDX_W-1:0] : TOP_IDX;
  end

  // next state for scale and held sample
  always_comb begin
    shift_d    = shift_q;
    shift_en   = 1'b0;
    pend_d     = pend_q;
    pend_lat_d = pend_lat_q;
    pend_en    = 1'b0;
    if (clear_i) begin
      shift_d  = '0;
      shift_en = 1'b1;
      pend_d   = 1'b0;
      pend_en  = 1'b1;
    end else begin
      unique case (mode)
        CTL_PARK: begin
          pend_d     = 1'b1;
          pend_lat_d = lat;
          pend_en    = 1'b1;
        end
        CTL_MERGE: begin
          shift_d  = shift_up[SHIFT_W-1:0];
          shift_en = 1'b1;
          if (pend_fits_up) begin
            pend_d  = 1'b0;
            pend_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_lat_q <= '0;
    end else if (pend_en) begin
      pend_q     <= pend_d;
      pend_lat_q <= pend_lat_d;
    end
  end

  // ---------------- bin storage ----------------
  mlh_bin_array #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W), .IDX_W(IDX_W)) u_bins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .merge_i (merge),
    .a_en_i  (a_en),
    .a_idx_i (a_idx),
    .b_en_i  (b_en),
    .b_idx_i (b_idx),
    .bins_o  (bins_o)
  );

  assign bin_shift_o = shift_q;
endmodule

// File: rtl/mlh_miss_histogram_chk.sv
module mlh_miss_histogram_chk #(
  parameter int NUM_BINS = 16,
  parameter int CNT_W    = 32,
  parameter int BIN_W    = 32,
  parameter int SHIFT_W  = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      clear_i,
  input logic                      hit_i,
  input logic                      miss_i,
  input logic                      fill_i,
  input logic [CNT_W-1:0]          hit_count_o,
  input logic [CNT_W-1:0]          miss_count_o,
  input logic [CNT_W-1:0]          sample_count_o,
  input logic [SHIFT_W-1:0]        bin_shift_o,
  input logic [NUM_BINS*BIN_W-1:0] bins_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1: one step per sampled hit
  assert_hit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && hit_i && hit_count_o != CNT_MAX) |=> hit_count_o == $past(hit_count_o) + 1'b1);

  // R2: one step per sampled miss
  assert_miss_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && miss_i && miss_count_o != CNT_MAX) |=> miss_count_o == $past(miss_count_o) + 1'b1);

  // R3: one step per sampled fill
  assert_sample_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && fill_i && sample_count_o != CNT_MAX) |=> sample_count_o == $past(sample_count_o) + 1'b1);

  // R5: scale grows by at most one per clock and never shrinks without clear
  assert_shift_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (bin_shift_o == $past(bin_shift_o) || bin_shift_o == $past(bin_shift_o) + 1'b1));

  // R10: clear empties everything
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hit_count_o == '0 && miss_count_o == '0 && sample_count_o == '0 &&
                 bin_shift_o == '0 && bins_o == '0));

  // R9: with the scale unchanged and no clear, no bin ever decreases
  for (genvar k = 0; k < NUM_BINS; k++) begin : g_mono
    assert_bin_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i ##1 $stable(bin_shift_o)) |->
        bins_o[k*BIN_W +: BIN_W] >= $past(bins_o[k*BIN_W +: BIN_W]));
  end
endmodule

bind mlh_miss_histogram mlh_miss_histogram_chk #(
  .NUM_BINS (NUM_BINS),
  .CNT_W    (CNT_W),
  .BIN_W    (BIN_W),
  .SHIFT_W  (SHIFT_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .hit_i          (hit_i),
  .miss_i         (miss_i),
  .fill_i         (fill_i),
  .hit_count_o    (hit_count_o),
  .miss_count_o   (miss_count_o),
  .sample_count_o (sample_count_o),
  .bin_shift_o    (bin_shift_o),
  .bins_o         (bins_o)
);

// File: tb/mlh_miss_histogram_tb.sv
`timescale 1ns/1ps
module mlh_miss_histogram_tb_top;
  localparam int NB        = 16;
  localparam int CW        = 6;
  localparam int BW        = 4;
  localparam int LW        = 12;
  localparam int MAXSH     = LW - $clog2(NB);
  localparam int SW        = $clog2(MAXSH + 1);
  localparam int BIN_MAX   = (1 << BW) - 1;
  localparam int CNT_MAX   = (1 << CW) - 1;
  localparam int NVEC      = 8;

  // stimulus: latency; expected scale after it
  localparam int LAT_TAB [NVEC] = '{3, 15, 1, 16, 40, 7, 200, 63};
  localparam int SH_TAB  [NVEC] = '{0,  0, 0,  1,  2, 2,   4,  4};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, hit_i = 1'b0, miss_i = 1'b0, fill_i = 1'b0;
  logic [CW-1:0]    hit_count_o, miss_count_o, sample_count_o;
  logic [SW-1:0]    bin_shift_o;
  logic [NB*BW-1:0] bins_o;

  always #2.5 clk_i = ~clk_i;

  mlh_miss_histogram #(.NUM_BINS(NB), .CNT_W(CW), .BIN_W(BW), .LAT_W(LW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .hit_i(hit_i),
    .miss_i(miss_i), .fill_i(fill_i), .hit_count_o(hit_count_o),
    .miss_count_o(miss_count_o), .sample_count_o(sample_count_o),
    .bin_shift_o(bin_shift_o), .bins_o(bins_o));

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // independent model of the requirements
  int m_bins [NB];
  int m_shift;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int get_bin(input int k);
    return int'(bins_o[k*BW +: BW]);
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NB; k++) m_bins[k] = 0;
    m_shift = 0;
  endtask

  task automatic model_add(input int lat);
    while ((lat >> m_shift) >= NB) begin
      for (int k = 0; k < NB; k++) begin
        if (k < NB/2) begin
          int s;
          s = m_bins[2*k] + m_bins[2*k+1];
          m_bins[k] = (s > BIN_MAX) ? BIN_MAX : s;
        end else m_bins[k] = 0;
      end
      m_shift++;
    end
    if (m_bins[lat >> m_shift] < BIN_MAX) m_bins[lat >> m_shift]++;
  endtask

  task automatic chk_bins(input string req);
    for (int k = 0; k < NB; k++) chk(req, $sformatf("bin %0d", k), get_bin(k), m_bins[k]);
  endtask

  task automatic settle();
    repeat (MAXSH + 4) @(negedge clk_i);
  endtask

  // one miss followed by its fill L edges later
  task automatic sample(input int lat);
    @(negedge clk_i) miss_i = 1'b1;
    @(negedge clk_i) miss_i = 1'b0;
    repeat (lat - 1) @(negedge clk_i);
    fill_i = 1'b1;
    @(negedge clk_i) fill_i = 1'b0;
    model_add(lat);
    settle();
  endtask

  task automatic do_clear();
    @(negedge clk_i) clear_i = 1'b1;
    @(negedge clk_i) clear_i = 1'b0;
    model_clear();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state (R10 / R5)
    chk("R1", "hit count after reset", int'(hit_count_o), 0);
    chk("R2", "miss count after reset", int'(miss_count_o), 0);
    chk("R3", "sample count after reset", int'(sample_count_o), 0);
    chk("R5", "shift after reset", int'(bin_shift_o), 0);
    chk("R10", "bins after reset", (bins_o == '0) ? 1 : 0, 1);

    // table walk: R4 direct binning, R6/R7 merging on overflow
    for (int i = 0; i < NVEC; i++) begin
      sample(LAT_TAB[i]);
      chk("R5", $sformatf("shift after vec %0d", i), int'(bin_shift_o), SH_TAB[i]);
      chk("R3", $sformatf("samples after vec %0d", i), int'(sample_count_o), i + 1);
      chk("R2", $sformatf("misses after vec %0d", i), int'(miss_count_o), i + 1);
      chk_bins("R4 R6 R7");
    end
    chk("R1", "no hits during table", int'(hit_count_o), 0);

    // R10: clear empties everything
    do_clear();
    @(negedge clk_i);
    chk("R10", "bins after clear", (bins_o == '0) ? 1 : 0, 1);
    chk("R10", "shift after clear", int'(bin_shift_o), 0);
    chk("R10", "samples after clear", int'(sample_count_o), 0);

    // R1 / R2: hit and miss in the same cycle both count
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); hit_i = 1'b1; miss_i = (i < 2);
    end
    @(negedge clk_i) begin hit_i = 1'b0; miss_i = 1'b0; end
    @(negedge clk_i);
    chk("R1", "hit count 5", int'(hit_count_o), 5);
    chk("R2", "miss count 2", int'(miss_count_o), 2);

    // R1 saturation
    hit_i = 1'b1;
    repeat (70) @(negedge clk_i);
    hit_i = 1'b0;
    @(negedge clk_i);
    chk("R1", "hit count saturated", int'(hit_count_o), CNT_MAX);

    // R10 priority over strobes
    @(negedge clk_i) begin clear_i = 1'b1; hit_i = 1'b1; miss_i = 1'b1; end
    @(negedge clk_i) begin clear_i = 1'b0; hit_i = 1'b0; miss_i = 1'b0; end
    model_clear();
    chk("R10", "hit count clear wins", int'(hit_count_o), 0);
    chk("R10", "miss count clear wins", int'(miss_count_o), 0);

    // R8: a short sample fills while a long one is still merging
    @(negedge clk_i) miss_i = 1'b1;
    @(negedge clk_i) miss_i = 1'b0;
    repeat (299) @(negedge clk_i);
    fill_i = 1'b1;
    @(negedge clk_i) begin fill_i = 1'b0; miss_i = 1'b1; end
    @(negedge clk_i) begin miss_i = 1'b0; fill_i = 1'b1; end
    @(negedge clk_i) fill_i = 1'b0;
    model_add(300);
    model_add(1);
    settle();
    chk("R8", "shift after fold", int'(bin_shift_o), 5);
    chk("R8", "samples after fold", int'(sample_count_o), 2);
    chk_bins("R8");

    // R9: bin saturation on increment and on merge
    do_clear();
    for (int i = 0; i < 16; i++) sample(2);
    for (int i = 0; i < 16; i++) sample(3);
    chk("R9", "bin 2 saturated", get_bin(2), BIN_MAX);
    chk("R9", "bin 3 saturated", get_bin(3), BIN_MAX);
    sample(16);
    chk("R9", "merged bin 1 saturated", get_bin(1), BIN_MAX);
    chk("R6", "shift after one merge", int'(bin_shift_o), 1);
    chk("R3", "samples after saturation run", int'(sample_count_o), 33);
    chk_bins("R6 R9");

    // R11: largest latency reaches the widest scale
    do_clear();
    sample((1 << LW) - 1);
    chk("R11", "shift at max latency", int'(bin_shift_o), MAXSH);
    chk("R11", "top bin holds max latency", get_bin(NB - 1), 1);
    chk_bins("R11");

    // R10: clear while a sample is held drops it
    do_clear();
    @(negedge clk_i) miss_i = 1'b1;
    @(negedge clk_i) miss_i = 1'b0;
    repeat (299) @(negedge clk_i);
    fill_i = 1'b1;
    @(negedge clk_i) begin fill_i = 1'b0; clear_i = 1'b1; end
    @(negedge clk_i) clear_i = 1'b0;
    settle();
    chk("R10", "shift after clear of held sample", int'(bin_shift_o), 0);
    chk("R10", "bins after clear of held sample", (bins_o == '0) ? 1 : 0, 1);
    sample(3);
    chk("R4", "bin 3 after clear", get_bin(3), 1);
    chk("R4", "shift stays 0", int'(bin_shift_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule